// File: doc/BRIEF.md
# Repeater Port Fault Guard

This block sits beside the forwarding core of a multi-port repeater and keeps one supervisory machine per port. From per-port indications of receive activity, whether a burst began with a valid start-of-packet sequence, whether the port was involved in a collision, and whether the line carries idle symbols, it decides which ports may feed the repeater and which may be fed by it. It also asks for a network-wide jam while a false carrier is in progress and gives each port a two-bit fault code for the indicator logic.

Three independent fault conditions are tracked per port. An overlong receive burst causes jabber shutdown. A run of collided bursts causes a partition. A false carrier that runs too long, or two false carriers in a row, causes isolation. Each condition has its own blocking rule and its own way out. Leaving isolation takes two steps: first a clean inter-packet gap, then either a long valid packet or a long idle period. Time is counted in symbol-clock cycles of four bit times each. Every threshold is a parameter given in bit times and converted to cycles at elaboration.

Top module: `seg_fault_guard`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every port reports code 00 (normal) on port_status, rx_ignore and tx_block are low, and jam_req is low.
- R2: A port whose rx_act stays high for more than 16384 consecutive cycles (65,536 bit times) reports code 11 (jabber) from the edge that samples its 16385th active cycle, with rx_ignore and tx_block both high. After exactly 16384 cycles it is not yet in jabber.
- R3: Jabber ends at the first clock edge that samples rx_act low on that port.
- R4: When a burst containing a collision ends and it is the 61st collided burst in a row on that port, the port becomes partitioned. The port reports code 01 unless a higher code applies, rx_ignore is high and tx_block stays low. Sixty collided bursts in a row do not partition the port.
- R5: A burst that starts with sop_ok high and ends with no collision clears the partition and restarts the collision count from zero.
- R6: A burst whose first cycle has sop_ok low is a false carrier. jam_req is high from the edge after its first cycle, and it stays high while the burst lasts, for up to 120 cycles (480 bit times).
- R7: A false carrier still active in its 121st cycle isolates the port, giving code 10, and its jam request drops at the same edge.
- R8: The end of a second false carrier with no clean valid packet between the two isolates the port. A clean valid packet between them resets that count.
- R9: An isolated or jabbering port has rx_ignore and tx_block high. A partitioned-only port has only rx_ignore high.
- R10: An isolated port becomes armed after 24 consecutive cycles with rx_act low and rx_idle high. When armed, a valid-start burst that is still active in its 121st cycle ends isolation at that edge. A gap of 23 such cycles does not arm the port.
- R11: An isolated port whose idle run (rx_act low, rx_idle high) reaches its 8251st consecutive cycle leaves isolation at that edge.
- R12: When several conditions hold, port_status shows jabber (11) over isolation (10) over partition (01).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 25 MHz symbol clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_act | input | N | Per-port receive activity |
| sop_ok | input | N | Per-port valid start-of-packet, sampled in a burst's first cycle |
| coll_hit | input | N | Per-port collision involvement during the current burst |
| rx_idle | input | N | Per-port idle symbols present on the line |
| rx_ignore | output | N | Per-port: discard this port's received data |
| tx_block | output | N | Per-port: send nothing to this port |
| jam_req | output | 1 | Jam all ports for a false carrier in progress |
| port_status | output | 2*N | Per-port fault code, bits [2p+1:2p] for port p |

## Verification
The hardest states to reach from the ports are the two ways out of isolation. Each depends on an exact count of quiet cycles before a burst, and a short gap must not arm recovery. Random traffic almost never lines these up, so directed sequences drive gaps of exactly 23 and 24 cycles followed by a 121-cycle valid packet, and an idle run of exactly 8250 and 8251 cycles. They also stack a collided jabber burst on a partitioned port to show the status priority. Randomized bursts of mixed length, start validity and collision flags run on all ports at once against a bench-side model.

// File: rtl/guard_pkg.sv
// Shared types and helpers for the repeater port fault guard.
// Assumes thresholds are given in bit times and converted to whole cycles.
package guard_pkg;

    // Per-port fault code, ordered so a larger value has higher priority
    typedef enum logic [1:0] {
        ST_OK   = 2'd0,
        ST_PART = 2'd1,
        ST_ISO  = 2'd2,
        ST_JAB  = 2'd3
    } guard_st_e;

    // Convert a bit-time threshold into symbol-clock cycles, rounding up
    function automatic int unsigned bits_to_cyc(input int unsigned bits,
                                                input int unsigned per_cyc);
        return (bits + per_cyc - 1) / per_cyc;
    endfunction

endpackage

// File: rtl/burst_track.sv
// Follows one port's receive bursts: edge detection, saturating burst
// length, whether the burst began as a false carrier and whether a
// collision touched it. Assumes sop is meaningful only in a burst's first cycle.
module burst_track #(
    parameter int unsigned RUN_MAX = 16384,
    parameter int unsigned RW      = $clog2(RUN_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act,
    input  logic          sop,
    input  logic          col,
    output logic          act_q,
    output logic          fc_q,
    output logic          col_q,
    output logic [RW-1:0] run_q,
    output logic          start,
    output logic          fin
);
    localparam logic [RW-1:0] RUN_TOP = RW'(RUN_MAX);

    assign start = act & ~act_q;
    assign fin   = ~act & act_q;

    // Register activity, burst length and burst attributes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            fc_q  <= 1'b0;
            col_q <= 1'b0;
            run_q <= '0;
        end else begin
            act_q <= act;
            if (!act)
                run_q <= '0;
            else if (start)
                run_q <= RW'(1);
            else if (run_q != RUN_TOP)
                run_q <= run_q + RW'(1);
            fc_q  <= act & (start ? ~sop : fc_q);
            col_q <= act & (start ? col : (col_q | col));
        end
    end
endmodule

// File: rtl/coll_part.sv
// Counts collided bursts in a row on one port and partitions the port
// when the run exceeds LIM. A clean valid burst clears both count and
// partition. Assumes fin pulses for one cycle at each burst end.
module coll_part #(
    parameter int unsigned LIM = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fin,
    input  logic fc_q,
    input  logic col_q,
    output logic part_q
);
    localparam int unsigned   CW   = $clog2(LIM + 2);
    localparam logic [CW-1:0] CTOP = CW'(LIM + 1);
    localparam logic [CW-1:0] CLIM = CW'(LIM);

    logic [CW-1:0] cnt_q;
    logic          hit;
    logic          clean;

    assign hit   = fin & col_q;
    assign clean = fin & ~fc_q & ~col_q;

    // Saturating consecutive-collision counter and partition flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            part_q <= 1'b0;
        end else if (hit) begin
            if (cnt_q != CTOP)
                cnt_q <= cnt_q + CW'(1);
            if (cnt_q >= CLIM)
                part_q <= 1'b1;
        end else if (clean) begin
            cnt_q  <= '0;
            part_q <= 1'b0;
        end
    end
endmodule

// File: rtl/iso_track.sv
// Isolation for one port: entered on an overlong false carrier or on
// FCN false carriers in a row; left after an arming gap of IPG_C quiet
// cycles followed by a valid burst longer than FC_C cycles, or after an
// idle run longer than IDLE_C cycles. Assumes IPG_C > 1 and FC_C < RUN_MAX.
module iso_track #(
    parameter int unsigned FC_C   = 120,
    parameter int unsigned IPG_C  = 24,
    parameter int unsigned IDLE_C = 8250,
    parameter int unsigned FCN    = 2,
    parameter int unsigned RW     = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act,
    input  logic          idle,
    input  logic          sop,
    input  logic          start,
    input  logic          fin,
    input  logic          act_q,
    input  logic          fc_q,
    input  logic          col_q,
    input  logic [RW-1:0] run_q,
    output logic          iso_q
);
    localparam int unsigned   IW    = $clog2(IDLE_C + 1);
    localparam int unsigned   NW    = $clog2(FCN + 1);
    localparam logic [RW-1:0] FC_V  = RW'(FC_C);
    localparam logic [IW-1:0] IDL_V = IW'(IDLE_C);
    localparam logic [IW-1:0] ARM_V = IW'(IPG_C - 1);
    localparam logic [NW-1:0] NTOP  = NW'(FCN);
    localparam logic [NW-1:0] NSET  = NW'(FCN - 1);

    logic [IW-1:0] idle_q;
    logic [NW-1:0] fcn_q;
    logic          armed_q;
    logic          quiet;
    logic          set_long;
    logic          set_two;
    logic          clr_pkt;
    logic          clr_idle;

    assign quiet    = ~act & idle;
    assign set_long = act & act_q & fc_q & (run_q >= FC_V);
    assign set_two  = fin & fc_q & (fcn_q >= NSET);
    assign clr_pkt  = iso_q & armed_q & act & act_q & ~fc_q & (run_q >= FC_V);
    assign clr_idle = iso_q & quiet & (idle_q >= IDL_V);

    // Length of the current quiet run, saturating at the idle threshold
    always_ff @(posedge clk) begin
        if (!rst_n)
            idle_q <= '0;
        else if (!quiet)
            idle_q <= '0;
        else if (idle_q != IDL_V)
            idle_q <= idle_q + IW'(1);
    end

    // False carriers in a row; cleared by recovery or a clean valid burst
    always_ff @(posedge clk) begin
        if (!rst_n)
            fcn_q <= '0;
        else if (clr_pkt | clr_idle)
            fcn_q <= '0;
        else if (fin & fc_q) begin
            if (fcn_q != NTOP)
                fcn_q <= fcn_q + NW'(1);
        end else if (fin & ~col_q)
            fcn_q <= '0;
    end

    // First recovery phase: a valid gap arms the port while isolated
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (!iso_q)
            armed_q <= 1'b0;
        else if (quiet && (idle_q >= ARM_V))
            armed_q <= 1'b1;
        else if (fin | (start & ~sop))
            armed_q <= 1'b0;
    end

    // Isolation flag: entry takes precedence over recovery
    always_ff @(posedge clk) begin
        if (!rst_n)
            iso_q <= 1'b0;
        else if (set_long | set_two)
            iso_q <= 1'b1;
        else if (clr_pkt | clr_idle)
            iso_q <= 1'b0;
    end
endmodule

// File: rtl/port_guard.sv
// One repeater port's complete guard: burst tracking, jabber shutdown,
// partition and isolation, merged into blocking flags, a false-carrier
// jam request and a prioritized fault code.
module port_guard
    import guard_pkg::*;
#(
    parameter int unsigned JAB_C  = 16384,
    parameter int unsigned FC_C   = 120,
    parameter int unsigned IPG_C  = 24,
    parameter int unsigned IDLE_C = 8250,
    parameter int unsigned LIM    = 60,
    parameter int unsigned FCN    = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      act,
    input  logic      sop,
    input  logic      col,
    input  logic      idle,
    output logic      ignore_o,
    output logic      block_o,
    output logic      jam_o,
    output guard_st_e st_o
);
    localparam int unsigned   RW    = $clog2(JAB_C + 1);
    localparam logic [RW-1:0] JAB_V = RW'(JAB_C);

    logic          act_q;
    logic          fc_q;
    logic          col_q;
    logic [RW-1:0] run_q;
    logic          start;
    logic          fin;
    logic          jab_q;
    logic          part_q;
    logic          iso_q;

    burst_track #(.RUN_MAX(JAB_C), .RW(RW)) u_bt (
        .clk(clk), .rst_n(rst_n), .act(act), .sop(sop), .col(col),
        .act_q(act_q), .fc_q(fc_q), .col_q(col_q), .run_q(run_q),
        .start(start), .fin(fin)
    );

    coll_part #(.LIM(LIM)) u_cp (
        .clk(clk), .rst_n(rst_n), .fin(fin), .fc_q(fc_q), .col_q(col_q),
        .part_q(part_q)
    );

    iso_track #(.FC_C(FC_C), .IPG_C(IPG_C), .IDLE_C(IDLE_C), .FCN(FCN), .RW(RW)) u_it (
        .clk(clk), .rst_n(rst_n), .act(act), .idle(idle), .sop(sop),
        .start(start), .fin(fin), .act_q(act_q), .fc_q(fc_q), .col_q(col_q),
        .run_q(run_q), .iso_q(iso_q)
    );

    // Jabber shutdown: set past the length limit, held until activity drops
    always_ff @(posedge clk) begin
        if (!rst_n)
            jab_q <= 1'b0;
        else
            jab_q <= act & (jab_q | (act_q & (run_q >= JAB_V)));
    end

    assign ignore_o = jab_q | iso_q | part_q;
    assign block_o  = jab_q | iso_q;
    assign jam_o    = fc_q & ~iso_q & ~jab_q;

    // Prioritized fault code for the indicator logic
    always_comb begin
        if (jab_q)
            st_o = ST_JAB;
        else if (iso_q)
            st_o = ST_ISO;
        else if (part_q)
            st_o = ST_PART;
        else
            st_o = ST_OK;
    end
endmodule

// File: rtl/seg_fault_guard.sv
// Top of the repeater port fault guard: one port_guard per port and a
// shared jam request. Thresholds are given in bit times and converted
// with BIT_PER_CYC bit times per symbol clock.
module seg_fault_guard
    import guard_pkg::*;
#(
    parameter int unsigned N           = 4,
    parameter int unsigned BIT_PER_CYC = 4,
    parameter int unsigned JAB_BITS    = 65536,
    parameter int unsigned FC_BITS     = 480,
    parameter int unsigned IPG_BITS    = 96,
    parameter int unsigned IDLE_BITS   = 33000,
    parameter int unsigned COLL_LIM    = 60,
    parameter int unsigned FC_RUN      = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   rx_act,
    input  logic [N-1:0]   sop_ok,
    input  logic [N-1:0]   coll_hit,
    input  logic [N-1:0]   rx_idle,
    output logic [N-1:0]   rx_ignore,
    output logic [N-1:0]   tx_block,
    output logic           jam_req,
    output logic [2*N-1:0] port_status
);
    localparam int unsigned JAB_C  = bits_to_cyc(JAB_BITS, BIT_PER_CYC);
    localparam int unsigned FC_C   = bits_to_cyc(FC_BITS, BIT_PER_CYC);
    localparam int unsigned IPG_C  = bits_to_cyc(IPG_BITS, BIT_PER_CYC);
    localparam int unsigned IDLE_C = bits_to_cyc(IDLE_BITS, BIT_PER_CYC);

    logic [N-1:0] jam_v;

    for (genvar p = 0; p < N; p++) begin : g_port
        guard_st_e st;

        port_guard #(
            .JAB_C(JAB_C), .FC_C(FC_C), .IPG_C(IPG_C), .IDLE_C(IDLE_C),
            .LIM(COLL_LIM), .FCN(FC_RUN)
        ) u_pg (
            .clk(clk), .rst_n(rst_n),
            .act(rx_act[p]), .sop(sop_ok[p]), .col(coll_hit[p]), .idle(rx_idle[p]),
            .ignore_o(rx_ignore[p]), .block_o(tx_block[p]), .jam_o(jam_v[p]),
            .st_o(st)
        );

        assign port_status[2*p +: 2] = st;
    end

    assign jam_req = |jam_v;
endmodule

// File: rtl/seg_fault_guard_chk.sv
// Temporal checks on the fault guard's ports, bound into every instance.
module seg_fault_guard_chk #(
    parameter int unsigned N = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [N-1:0]   rx_act,
    input logic [N-1:0]   rx_ignore,
    input logic [N-1:0]   tx_block,
    input logic           jam_req,
    input logic [2*N-1:0] port_status
);
    AST_JAM_NEEDS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        jam_req |-> $past(|rx_act)); // R6

    for (genvar i = 0; i < N; i++) begin : g_chk
        AST_JAB_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
            !rx_act[i] |=> (port_status[2*i +: 2] != 2'b11)); // R3
        AST_JAB_NEEDS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
            (port_status[2*i +: 2] == 2'b11) |-> $past(rx_act[i])); // R2
        AST_PART_TX_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
            (port_status[2*i +: 2] == 2'b01) |-> (rx_ignore[i] && !tx_block[i])); // R4
        AST_ISO_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
            (port_status[2*i +: 2] == 2'b10) |-> (rx_ignore[i] && tx_block[i])); // R9
        AST_BLOCK_HAS_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
            tx_block[i] |-> rx_ignore[i]); // R9
    end
endmodule

bind seg_fault_guard seg_fault_guard_chk #(.N(N)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_act(rx_act), .rx_ignore(rx_ignore),
    .tx_block(tx_block), .jam_req(jam_req), .port_status(port_status)
);

// File: tb/sim_seg_fault_guard.sv
`timescale 1ns/1ps
module sim_seg_fault_guard;
    localparam int N      = 4;
    localparam int JAB_C  = 16384;
    localparam int FC_C   = 120;
    localparam int IPG_C  = 24;
    localparam int IDLE_C = 8250;
    localparam int LIM    = 60;

    logic           clk    = 1'b0;
    logic           rst_n  = 1'b0;
    logic [N-1:0]   d_act  = '0;
    logic [N-1:0]   d_sop  = '0;
    logic [N-1:0]   d_col  = '0;
    logic [N-1:0]   d_idle = '1;
    logic [N-1:0]   rx_ignore;
    logic [N-1:0]   tx_block;
    logic           jam_req;
    logic [2*N-1:0] port_status;

    seg_fault_guard #(.N(N)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_act(d_act), .sop_ok(d_sop),
        .coll_hit(d_col), .rx_idle(d_idle), .rx_ignore(rx_ignore),
        .tx_block(tx_block), .jam_req(jam_req), .port_status(port_status)
    );

    always #4 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // Bench model of each port, written from the requirements
    bit m_act[N], m_fc[N], m_col[N], m_jab[N], m_part[N], m_iso[N], m_arm[N];
    int m_len[N], m_idle[N], m_cc[N], m_fn[N];

    function automatic logic [1:0] m_stat(int p);
        if (m_jab[p]) return 2'b11;
        if (m_iso[p]) return 2'b10;
        if (m_part[p]) return 2'b01;
        return 2'b00;
    endfunction

    function automatic string stag(logic [1:0] a, logic [1:0] b);
        logic [1:0] m = (a > b) ? a : b;
        case (m)
            2'b11:   return "R2";
            2'b10:   return "R7";
            2'b01:   return "R4";
            default: return "R1";
        endcase
    endfunction

    task automatic model_reset();
        for (int p = 0; p < N; p++) begin
            m_act[p] = 0; m_fc[p] = 0; m_col[p] = 0; m_jab[p] = 0; m_part[p] = 0;
            m_iso[p] = 0; m_arm[p] = 0; m_len[p] = 0; m_idle[p] = 0; m_cc[p] = 0; m_fn[p] = 0;
        end
    endtask

    task automatic model_step();
        for (int p = 0; p < N; p++) begin
            bit a, s, c, q, st, fn, set_l, set_t, clr_p, clr_i, clean, hit, n_arm, n_iso;
            a = d_act[p]; s = d_sop[p]; c = d_col[p]; q = !d_act[p] && d_idle[p];
            st = a && !m_act[p]; fn = !a && m_act[p];
            set_l = a && m_act[p] && m_fc[p] && m_len[p] >= FC_C;
            set_t = fn && m_fc[p] && m_fn[p] >= 1;
            clr_p = m_iso[p] && m_arm[p] && a && m_act[p] && !m_fc[p] && m_len[p] >= FC_C;
            clr_i = m_iso[p] && q && m_idle[p] >= IDLE_C;
            clean = fn && !m_fc[p] && !m_col[p];
            hit   = fn && m_col[p];
            if (!m_iso[p]) n_arm = 0;
            else if (q && m_idle[p] >= IPG_C - 1) n_arm = 1;
            else if (fn || (st && !s)) n_arm = 0;
            else n_arm = m_arm[p];
            n_iso = (set_l || set_t) ? 1 : ((clr_p || clr_i) ? 0 : m_iso[p]);
            if (hit) begin
                if (m_cc[p] >= LIM) m_part[p] = 1;
                if (m_cc[p] < LIM + 1) m_cc[p]++;
            end else if (clean) begin
                m_cc[p] = 0; m_part[p] = 0;
            end
            if (clr_p || clr_i) m_fn[p] = 0;
            else if (fn && m_fc[p]) m_fn[p] = (m_fn[p] < 2) ? m_fn[p] + 1 : 2;
            else if (clean) m_fn[p] = 0;
            m_jab[p]  = a && (m_jab[p] || (m_act[p] && m_len[p] >= JAB_C));
            m_idle[p] = q ? ((m_idle[p] < IDLE_C) ? m_idle[p] + 1 : IDLE_C) : 0;
            m_len[p]  = a ? (m_act[p] ? ((m_len[p] < JAB_C) ? m_len[p] + 1 : JAB_C) : 1) : 0;
            m_fc[p]   = a ? (st ? !s : m_fc[p]) : 0;
            m_col[p]  = a ? (st ? c : (m_col[p] || c)) : 0;
            m_act[p]  = a;
            m_arm[p]  = n_arm;
            m_iso[p]  = n_iso;
        end
    endtask

    task automatic cmp(string tag, int p, string what, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s port %0d %s actual=%0h expected=%0h", tag, p, what, got, exp);
        end
    endtask

    task automatic check_all();
        bit jam_e = 0;
        for (int p = 0; p < N; p++) begin
            cmp(stag(port_status[2*p +: 2], m_stat(p)), p, "status",
                32'(port_status[2*p +: 2]), 32'(m_stat(p)));
            cmp("R9", p, "rx_ignore", 32'(rx_ignore[p]), 32'(m_jab[p] | m_iso[p] | m_part[p]));
            cmp("R9", p, "tx_block", 32'(tx_block[p]), 32'(m_jab[p] | m_iso[p]));
            jam_e |= m_fc[p] && !m_iso[p] && !m_jab[p];
        end
        cmp("R6", -1, "jam_req", 32'(jam_req), 32'(jam_e));
    endtask

    task automatic cycle();
        @(posedge clk);
        if (rst_n) model_step(); else model_reset();
        @(negedge clk);
        if (rst_n) check_all();
    endtask

    task automatic do_reset();
        d_act = '0; d_sop = '0; d_col = '0; d_idle = '1;
        rst_n = 0;
        repeat (3) cycle();
        rst_n = 1;
    endtask

    task automatic burst(int p, int len, bit sop, bit col);
        d_act[p] = 1; d_sop[p] = sop; d_col[p] = col;
        repeat (len) cycle();
        d_act[p] = 0; d_sop[p] = 0; d_col[p] = 0;
    endtask

    task automatic quiet(int p, int n);
        d_idle[p] = 1;
        repeat (n) cycle();
    endtask

    task automatic expect_st(string tag, int p, logic [1:0] e);
        cmp(tag, p, "status", 32'(port_status[2*p +: 2]), 32'(e));
    endtask

    task automatic rand_run(int n);
        int rem[N];
        for (int p = 0; p < N; p++) rem[p] = 0;
        for (int k = 0; k < n; k++) begin
            for (int p = 0; p < N; p++) begin
                if (rem[p] == 0) begin
                    if (d_act[p]) begin
                        d_act[p] = 0; d_col[p] = 0;
                        d_idle[p] = ($urandom % 100) < 85;
                        rem[p] = 1 + $urandom % 40;
                    end else begin
                        d_act[p] = 1;
                        d_sop[p] = ($urandom % 10) < 7;
                        d_col[p] = ($urandom % 10) < 3;
                        rem[p] = 1 + $urandom % 170;
                    end
                end
                rem[p]--;
            end
            cycle();
        end
        d_act = '0; d_col = '0; d_idle = '1;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        void'($urandom(32'd4417));
        do_reset();
        // R1: state right after reset
        for (int p = 0; p < N; p++) begin
            expect_st("R1", p, 2'b00);
            cmp("R1", p, "rx_ignore", 32'(rx_ignore[p]), 0);
            cmp("R1", p, "tx_block", 32'(tx_block[p]), 0);
        end
        cmp("R1", -1, "jam_req", 32'(jam_req), 0);

        rand_run(20000);
        do_reset();

        // R2 and R3: jabber boundary and exit on port 0
        d_act[0] = 1; d_sop[0] = 1;
        repeat (JAB_C) cycle();
        expect_st("R2", 0, 2'b00);
        cycle();
        expect_st("R2", 0, 2'b11);
        cmp("R2", 0, "tx_block", 32'(tx_block[0]), 1);
        cycle();
        d_act[0] = 0; d_sop[0] = 0;
        cycle();
        expect_st("R3", 0, 2'b00);

        // R4 and R5: partition threshold, release and count restart on port 1
        for (int k = 0; k < LIM; k++) begin burst(1, 3, 1, 1); quiet(1, 3); end
        expect_st("R4", 1, 2'b00);
        burst(1, 3, 1, 1); quiet(1, 3);
        expect_st("R4", 1, 2'b01);
        cmp("R4", 1, "rx_ignore", 32'(rx_ignore[1]), 1);
        cmp("R4", 1, "tx_block", 32'(tx_block[1]), 0);
        burst(1, 5, 1, 0); quiet(1, 1);
        expect_st("R5", 1, 2'b00);
        for (int k = 0; k < LIM; k++) begin burst(1, 3, 1, 1); quiet(1, 3); end
        expect_st("R5", 1, 2'b00);
        burst(1, 5, 1, 0); quiet(1, 2);

        // R6, R7, R10: long false carrier then gap-armed packet recovery on port 2
        d_act[2] = 1; d_sop[2] = 0;
        cycle();
        cmp("R6", 2, "jam_req", 32'(jam_req), 1);
        repeat (FC_C - 1) cycle();
        cmp("R6", 2, "jam_req", 32'(jam_req), 1);
        expect_st("R6", 2, 2'b00);
        cycle();
        cmp("R7", 2, "jam_req", 32'(jam_req), 0);
        expect_st("R7", 2, 2'b10);
        cmp("R9", 2, "tx_block", 32'(tx_block[2]), 1);
        d_act[2] = 0;
        quiet(2, IPG_C - 1);
        d_act[2] = 1; d_sop[2] = 1;
        repeat (FC_C + 1) cycle();
        expect_st("R10", 2, 2'b10);
        d_act[2] = 0; d_sop[2] = 0;
        quiet(2, IPG_C);
        d_act[2] = 1; d_sop[2] = 1;
        repeat (FC_C) cycle();
        expect_st("R10", 2, 2'b10);
        cycle();
        expect_st("R10", 2, 2'b00);
        d_act[2] = 0; d_sop[2] = 0;
        quiet(2, 2);

        // R8 and R11: successive false carriers, then idle recovery on port 3
        burst(3, 5, 0, 0); quiet(3, 5);
        burst(3, 5, 1, 0); quiet(3, 5);
        burst(3, 5, 0, 0); quiet(3, 5);
        expect_st("R8", 3, 2'b00);
        burst(3, 5, 0, 0); quiet(3, 1);
        expect_st("R8", 3, 2'b10);
        quiet(3, IDLE_C - 1);
        expect_st("R11", 3, 2'b10);
        quiet(3, 1);
        expect_st("R11", 3, 2'b00);

        // R12: priority of stacked conditions on port 0
        do_reset();
        for (int k = 0; k <= LIM; k++) begin burst(0, 3, 1, 1); quiet(0, 3); end
        expect_st("R12", 0, 2'b01);
        d_act[0] = 1; d_sop[0] = 1; d_col[0] = 1;
        repeat (JAB_C + 1) cycle();
        expect_st("R12", 0, 2'b11);
        d_act[0] = 0; d_sop[0] = 0; d_col[0] = 0;
        cycle();
        expect_st("R12", 0, 2'b01);
        burst(0, 5, 0, 0); quiet(0, 5);
        burst(0, 5, 0, 0); quiet(0, 1);
        expect_st("R12", 0, 2'b10);

        rand_run(3000);
        finish_up();
    end
endmodule